// File: doc/BRIEF.md
# GPIO Interrupt Event Detector and Aggregator

This block watches the already-synchronized input level of every GPIO pin and turns pin activity into interrupt requests. Each pin carries a 2-bit mode made of a trigger-select bit and an invert bit. The mode selects rising-edge, falling-edge, level-low or level-high detection. A detected event sets a sticky per-pin status bit. Software clears a status bit by writing a one to it.

Status and enable bits are grouped into data words for a simple register bus. Word index w holds pins w*WORD_W up to w*WORD_W+WORD_W-1, so the default build has three words: pins 0-31, 32-63 and 64-94. A pin is pending only when both its status bit and its enable bit are set. The pending bits are ORed into one interrupt line, and that line is registered.

The configuration storage that supplies the mode and input-sensing bits lives elsewhere. The routing of the interrupt line to a system interrupt controller also lives elsewhere.

Top module: `gpio_irq_agg`

## Requirements
- R1: With trigger-select 0 and invert 0, a low-to-high change of the pin level between two consecutive clocks sets that pin's status bit. The bit can be read back on the next cycle.
- R2: With trigger-select 0 and invert 1, a high-to-low change sets the status bit. A low-to-high change in this mode sets nothing.
- R3: With trigger-select 1 and invert 0, the status bit is set on every clock while the pin is low. A clearing write made while the pin is still low leaves the bit set.
- R4: With trigger-select 1 and invert 1, the status bit is set on every clock while the pin is high. While the pin is low nothing is set.
- R5: A write to a status word clears exactly the bits written as 1 and leaves the bits written as 0 unchanged. Writing 0xFFFFFFFF clears the whole word.
- R6: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: An event sets its status bit even when the pin's enable bit is 0. The enable bit only masks the interrupt line.
- R8: irq_o is high in the cycle after some status bit and its enable bit are both set. It falls in the cycle after the last such pair goes away.
- R9: A pin whose input-sensing bit is 0 produces no events in any mode.
- R10: The address encoding is as follows. Bit ADDR_W-1 = 0 selects status and 1 selects enable. The low bits give the word index. Reads are combinational. Index values of NUM_WORDS or more read as 0 and ignore writes. Bit positions with no pin read as 0 and cannot be written.
- R11: After reset, all status bits, all enable bits and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_lvl_i | input | NUM_PINS | Synchronized pin levels |
| trig_sel_i | input | NUM_PINS | Per-pin trigger select: 0 edge, 1 level |
| inv_i | input | NUM_PINS | Per-pin invert: picks falling edge or high level |
| sense_en_i | input | NUM_PINS | Per-pin input-sensing enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address: bank bit and word index |
| wr_data_i | input | WORD_W | Write data: ones to clear for status, new value for enable |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | WORD_W | Combinational read data |
| irq_o | output | 1 | Registered aggregate interrupt |

## Verification
The bench builds the block with its defaults, NUM_PINS = 95 and WORD_W = 32. This gives two full words and a third word that holds only 31 pins. The partial word brings the unused top bit and the unused fourth index of the 2-bit word field within reach, and both are written and read back. Pins in each of the three words are driven through all four detection modes. The cases covered are a clear racing an edge in the same cycle, clearing writes made during an active level, and the one-cycle lag of the interrupt line after enable and clear writes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // {trigger_select, invert}
  typedef enum logic [1:0] {
    MODE_RISE   = 2'b00,
    MODE_FALL   = 2'b01,
    MODE_LVL_LO = 2'b10,
    MODE_LVL_HI = 2'b11
  } trig_mode_e;

  function automatic logic pin_event(trig_mode_e mode, logic lvl, logic prev);
    logic ev;
    case (mode)
      MODE_RISE:   ev = lvl & ~prev;
      MODE_FALL:   ev = ~lvl & prev;
      MODE_LVL_LO: ev = ~lvl;
      MODE_LVL_HI: ev = lvl;
      default:     ev = 1'b0;
    endcase
    return ev;
  endfunction

endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 95
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] trig_i,
  input  logic [NUM_PINS-1:0] inv_i,
  input  logic [NUM_PINS-1:0] sense_i,
  output logic [NUM_PINS-1:0] evt_o
);

  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    trig_mode_e mode;
    assign mode     = trig_mode_e'({trig_i[p], inv_i[p]});
    assign evt_o[p] = sense_i[p] & pin_event(mode, lvl_i[p], prev_q[p]);

    // R1: a sensed rising change in edge mode must raise an event
    a_r1_rise_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_i[p] && !trig_i[p] && !inv_i[p] && lvl_i[p] && !$past(lvl_i[p]))
        |-> evt_o[p]);

    // R3/R4: active level in level mode raises an event every cycle
    a_r4_level_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_i[p] && trig_i[p] && (lvl_i[p] == inv_i[p])) |-> evt_o[p]);
  end

endmodule

// File: rtl/gpio_irq_word.sv
module gpio_irq_word #(
  parameter int                WORD_W     = 32,
  parameter logic [WORD_W-1:0] VALID_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] evt_i,
  input  logic              clr_we_i,
  input  logic              en_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] sts_o,
  output logic [WORD_W-1:0] en_o,
  output logic              pend_o
);

  logic [WORD_W-1:0] sts_q, en_q, clr_mask;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  // event set dominates the write-one clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= ((sts_q & ~clr_mask) | evt_i) & VALID_MASK;
      if (en_we_i) en_q <= wdata_i & VALID_MASK;
    end
  end

  assign sts_o  = sts_q;
  assign en_o   = en_q;
  assign pend_o = |(sts_q & en_q);

  a_r6_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & VALID_MASK) != '0)
      |=> ((sts_q & $past(evt_i & VALID_MASK)) == $past(evt_i & VALID_MASK)));

  a_r5_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((sts_q & $past(wdata_i & ~evt_i)) == '0));

  a_r5_unwritten_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_q & $past(sts_q & ~clr_mask)) == $past(sts_q & ~clr_mask)));

endmodule

// File: rtl/gpio_irq_reduce.sv
module gpio_irq_reduce #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  output logic         irq_o
);

  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |pend_i;
  end

  assign irq_o = irq_q;

  a_r8_irq_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|pend_i));

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
  parameter int NUM_PINS  = 95,
  parameter int WORD_W    = 32,
  localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W,
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W    = IDX_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_lvl_i,
  input  logic [NUM_PINS-1:0] trig_sel_i,
  input  logic [NUM_PINS-1:0] inv_i,
  input  logic [NUM_PINS-1:0] sense_en_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [WORD_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [WORD_W-1:0]   rd_data_o,
  output logic                irq_o
);

  localparam int PAD_W = NUM_WORDS * WORD_W;

  logic [NUM_PINS-1:0]  evt;
  logic [PAD_W-1:0]     evt_pad;
  logic [WORD_W-1:0]    sts_w [NUM_WORDS];
  logic [WORD_W-1:0]    en_w  [NUM_WORDS];
  logic [NUM_WORDS-1:0] pend;

  logic             wr_bank_en, rd_bank_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign wr_bank_en = wr_addr_i[ADDR_W-1];
  assign wr_idx     = wr_addr_i[IDX_W-1:0];
  assign rd_bank_en = rd_addr_i[ADDR_W-1];
  assign rd_idx     = rd_addr_i[IDX_W-1:0];

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (pin_lvl_i),
    .trig_i  (trig_sel_i),
    .inv_i   (inv_i),
    .sense_i (sense_en_i),
    .evt_o   (evt)
  );

  assign evt_pad = PAD_W'(evt);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int VB = (NUM_PINS - w * WORD_W >= WORD_W) ? WORD_W
                                                          : NUM_PINS - w * WORD_W;
    localparam logic [WORD_W-1:0] VMASK = {WORD_W{1'b1}} >> (WORD_W - VB);

    logic hit;
    assign hit = wr_en_i && (wr_idx == IDX_W'(w));

    gpio_irq_word #(.WORD_W(WORD_W), .VALID_MASK(VMASK)) u_word (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_pad[w*WORD_W +: WORD_W]),
      .clr_we_i (hit && !wr_bank_en),
      .en_we_i  (hit && wr_bank_en),
      .wdata_i  (wr_data_i),
      .sts_o    (sts_w[w]),
      .en_o     (en_w[w]),
      .pend_o   (pend[w])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (rd_idx == IDX_W'(w)) rd_data_o = rd_bank_en ? en_w[w] : sts_w[w];
    end
  end

  gpio_irq_reduce #(.N(NUM_WORDS)) u_reduce (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .irq_o  (irq_o)
  );

endmodule

// File: tb/gpio_irq_agg_bench.sv
module gpio_irq_agg_bench;

  localparam int NP = 95;
  localparam int WW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_lvl = '0, trig = '0, inv = '0, sense = '1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [WW-1:0] wr_data = '0, rd_data;
  logic          irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_irq_agg u_gpio_irq_agg (
    .clk_i(clk), .rst_ni(rst_n), .pin_lvl_i(pin_lvl), .trig_sel_i(trig),
    .inv_i(inv), .sense_en_i(sense), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  typedef struct {
    bit            is_irq;
    logic [WW-1:0] exp;
    string         tag;
  } item_t;

  item_t sb_q[$];

  // monitor: one expected item per falling edge
  always @(negedge clk) begin
    item_t it;
    logic [WW-1:0] act;
    if (sb_q.size() != 0) begin
      it  = sb_q.pop_front();
      act = it.is_irq ? {{(WW-1){1'b0}}, irq} : rd_data;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk_reg(input logic [AW-1:0] a, input logic [WW-1:0] e, input string tag);
    item_t it;
    rd_addr = a;
    it.is_irq = 0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1; it.exp = {{(WW-1){1'b0}}, e}; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [WW-1:0] d);
    tick();
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic set_pin(input int p, input logic v);
    tick();
    pin_lvl[p] = v;
    tick();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R11 reset state
    chk_reg(3'd0, 32'h0, "R11 status0");
    chk_reg(3'd1, 32'h0, "R11 status1");
    chk_reg(3'd2, 32'h0, "R11 status2");
    chk_reg(3'd4, 32'h0, "R11 enable0");
    chk_irq(1'b0, "R11 irq");

    // R1 rising edge, R7 enable off
    set_pin(3, 1'b1);
    chk_reg(3'd0, 32'h8, "R1 rise sets bit3");
    chk_irq(1'b0, "R7 masked irq");
    chk_reg(3'd0, 32'h8, "R7 status set with enable 0");

    // R5 write-one-to-clear
    wr(3'd0, 32'h0);
    chk_reg(3'd0, 32'h8, "R5 zero write keeps");
    set_pin(10, 1'b1);
    wr(3'd0, 32'h8);
    chk_reg(3'd0, 32'h400, "R5 selective clear");
    wr(3'd0, 32'hFFFF_FFFF);
    chk_reg(3'd0, 32'h0, "R5 all-ones clear");

    // R2 falling edge on pin 40 (word1 bit8)
    tick(); inv[40] = 1'b1;
    set_pin(40, 1'b1);
    chk_reg(3'd1, 32'h0, "R2 rise ignored");
    set_pin(40, 1'b0);
    chk_reg(3'd1, 32'h100, "R2 fall sets");

    // R8 latency of irq
    wr(3'd5, 32'h100);
    chk_irq(1'b0, "R8 irq lags enable");
    chk_irq(1'b1, "R8 irq rises");
    chk_reg(3'd5, 32'h100, "R10 enable readback");
    wr(3'd1, 32'h100);
    chk_irq(1'b1, "R8 irq lags clear");
    chk_irq(1'b0, "R8 irq falls");

    // R3 level-low on pin 70 (word2 bit6)
    tick(); trig[70] = 1'b1;
    tick(); tick();
    chk_reg(3'd2, 32'h40, "R3 low level sets");
    wr(3'd2, 32'h40);
    chk_reg(3'd2, 32'h40, "R3 clear under active level");
    set_pin(70, 1'b1);
    wr(3'd2, 32'h40);
    chk_reg(3'd2, 32'h0, "R3 released then cleared");

    // R4 level-high on pin 94 (word2 bit30)
    tick(); trig[94] = 1'b1; inv[94] = 1'b1;
    tick();
    chk_reg(3'd2, 32'h0, "R4 inactive low");
    set_pin(94, 1'b1);
    chk_reg(3'd2, 32'h4000_0000, "R4 high sets");
    wr(3'd6, 32'hFFFF_FFFF);
    chk_reg(3'd6, 32'h7FFF_FFFF, "R10 unused bit not writable");
    chk_irq(1'b1, "R8 level irq");
    set_pin(94, 1'b0);
    wr(3'd2, 32'hFFFF_FFFF);
    chk_reg(3'd2, 32'h0, "R4 cleared after low");
    wr(3'd6, 32'h0);

    // R9 sensing disabled
    tick(); sense[5] = 1'b0; sense[70] = 1'b0;
    set_pin(5, 1'b1);
    chk_reg(3'd0, 32'h0, "R9 edge suppressed");
    set_pin(70, 1'b0);
    chk_reg(3'd2, 32'h0, "R9 level suppressed");

    // R6 event beats simultaneous clear
    set_pin(3, 1'b0);
    tick();
    pin_lvl[3] = 1'b1;
    wr_en = 1; wr_addr = 3'd0; wr_data = 32'h8;
    tick();
    wr_en = 0;
    chk_reg(3'd0, 32'h8, "R6 event wins");

    // R10 word mapping and out-of-range index
    set_pin(64, 1'b1);
    set_pin(32, 1'b1);
    chk_reg(3'd2, 32'h1, "R10 pin64 -> word2 bit0");
    chk_reg(3'd1, 32'h1, "R10 pin32 -> word1 bit0");
    chk_reg(3'd3, 32'h0, "R10 unused index reads 0");
    wr(3'd3, 32'hFFFF_FFFF);
    chk_reg(3'd2, 32'h1, "R10 unused index write ignored");
    chk_reg(3'd0, 32'h8, "R10 word0 unaffected");

    tick();
    done = 1;
    summary();
    $finish;
  end

endmodule